// File: doc/BRIEF.md
# Priority Layer Pixel Compositor

This block merges a fixed stack of programmable graphic layers, a cursor and a background colour into one 24-bit RGB pixel per raster position. For every incoming position it works out which layers lie over the pixel, drops those whose colour falls inside their transparency window, keeps only the topmost few of what remains, and alpha-blends the kept pixels from the lowest one up to the highest one. Source pixels arrive already fetched, one 32-bit ARGB word per source, with the raster coordinates of the position, on a valid/ready stream.

Software-side settings are held per source: an enable bit, a signed x/y origin, a width and height, a global alpha and a colour-key window with per-channel lower and upper limits. A shared setting holds the background colour and the number of extra blend slots beyond the first two. All writes land in a shadow copy and only reach the working copy on a frame-start strobe. The design is a three-register pipeline that takes one pixel per clock. Back-pressure on the output freezes every stage.

Top module: `layer_compositor`

## Requirements
- R1: Source i covers pixel (px,py) when its signed origin (x,y) and size (w,h) satisfy x <= px < x+w and y <= py < y+h. Both edges are half-open. An origin left of or above the panel is allowed.
- R2: Sources have a fixed priority. A higher index lies above a lower index. The cursor occupies slot NUM_LAYERS and lies above every programmable layer. An opaque higher source hides everything beneath it.
- R3: Only the topmost K eligible sources are blended, with K = 2 + min(extra, BLEND_CAP-2). Any eligible source below them has no effect. An extra value above the cap behaves as the cap.
- R4: The alpha of the lowest selected source is ignored, and that source is taken as fully opaque.
- R5: When a source's key enable is set and its R, G and B each lie inside [lo,hi] inclusive, the pixel is transparent and takes no blend slot. R is bits 23:16, G is 15:8 and B is 7:0 of both the pixel and the limits.
- R6: Each step blends one source over the result so far. Per channel the step is out = (a*src + (255-a)*dst + 127)/255, with integer division. The effective alpha is a = (pixel_alpha*global_alpha + 127)/255, and the pixel alpha is bits 31:24 of the ARGB word.
- R7: A position with no eligible source outputs the background colour.
- R8: A source whose enable bit is clear never covers any pixel.
- R9: Descriptor and shared-setting writes have no effect on output until a frame_start pulse copies the shadow values to the working set.
- R10: One pixel is accepted per clock. The result appears three accepting clock edges after the pixel is taken. While out_valid is high and out_ready is low, in_ready is low and out_rgb holds its value. Pixels leave in the order they arrived.
- R11: After reset out_valid is 0, in_ready is 1, every source is disabled and the background is 0x000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write the shadow descriptor picked by cfg_sel |
| cfg_sel | input | $clog2(NUM_LAYERS+1) | Source index; NUM_LAYERS selects the cursor |
| cfg_en | input | 1 | Source enable |
| cfg_x | input | COORD_W+1 | Signed x origin |
| cfg_y | input | COORD_W+1 | Signed y origin |
| cfg_w | input | COORD_W | Width in pixels |
| cfg_h | input | COORD_W | Height in pixels |
| cfg_galpha | input | 8 | Global alpha of the source |
| cfg_key_en | input | 1 | Colour-key enable |
| cfg_key_lo | input | 24 | Colour-key lower limits, RGB |
| cfg_key_hi | input | 24 | Colour-key upper limits, RGB |
| glb_we | input | 1 | Write the shadow shared settings |
| glb_extra | input | EXTRA_W | Extra blend slots beyond two |
| glb_bg | input | 24 | Background colour, RGB |
| frame_start | input | 1 | Copy shadow settings to the working set |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_x | input | COORD_W | Raster column |
| in_y | input | COORD_W | Raster row |
| in_pix | input | 32*(NUM_LAYERS+1) | ARGB word of source i at bits 32*i+31:32*i |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_rgb | output | 24 | Composited RGB pixel |

## Verification
The checker assumes the downstream side never drops a pixel. It treats a beat as delivered only when out_valid and out_ready are both high. It also assumes frame_start is the only event that may change the working settings. Its occupancy bound of three therefore holds only when reset clears the pipeline. The stimulus keeps within this: it changes in_valid and the pixel fields only on falling edges, and it holds a refused pixel steady until it is accepted. It pulses frame_start for a single cycle, never in the same cycle as a shadow write, so every pixel in flight sees one consistent set of settings.

// File: rtl/lcomp_pkg.sv
package lcomp_pkg;

   localparam int CH_W  = 8;
   localparam int RGB_W = 24;
   localparam int PIX_W = 32;

   // rounded division by 255 of a product-sized value
   function automatic logic [7:0] div255(input logic [16:0] num);
      logic [17:0] t;
      t = {1'b0, num} + 18'd127;
      return 8'(t / 18'd255);
   endfunction

   function automatic logic [7:0] scale_alpha(input logic [7:0] pa, input logic [7:0] ga);
      logic [16:0] p;
      p = {9'd0, pa} * {9'd0, ga};
      return div255(p);
   endfunction

   function automatic logic [7:0] mix_ch(input logic [7:0] a, input logic [7:0] s,
                                         input logic [7:0] d);
      logic [16:0] p;
      p = {9'd0, a} * {9'd0, s} + {9'd0, 8'(8'd255 - a)} * {9'd0, d};
      return div255(p);
   endfunction

   function automatic logic [23:0] mix_rgb(input logic [7:0] a, input logic [23:0] s,
                                           input logic [23:0] d);
      logic [23:0] r;
      for (int c = 0; c < 3; c++)
         r[8*c +: 8] = mix_ch(a, s[8*c +: 8], d[8*c +: 8]);
      return r;
   endfunction

endpackage

// File: rtl/lcomp_probe.sv
module lcomp_probe #(
   parameter int COORD_W = 12
) (
   input  logic               en,
   input  logic [COORD_W:0]   pos_x,
   input  logic [COORD_W:0]   pos_y,
   input  logic [COORD_W-1:0] size_w,
   input  logic [COORD_W-1:0] size_h,
   input  logic [7:0]         galpha,
   input  logic               key_en,
   input  logic [23:0]        key_lo,
   input  logic [23:0]        key_hi,
   input  logic [COORD_W-1:0] px,
   input  logic [COORD_W-1:0] py,
   input  logic [31:0]        pix,
   output logic               elig,
   output logic [7:0]         eff_a,
   output logic [23:0]        rgb
);
   localparam int EW = COORD_W + 2;

   logic signed [EW-1:0] x_lo, x_hi, y_lo, y_hi, cx, cy;
   logic                 hit;
   logic [2:0]           ch_in;
   logic                 keyed;

   assign x_lo = $signed({pos_x[COORD_W], pos_x});
   assign y_lo = $signed({pos_y[COORD_W], pos_y});
   assign x_hi = x_lo + $signed({2'b00, size_w});
   assign y_hi = y_lo + $signed({2'b00, size_h});
   assign cx   = $signed({2'b00, px});
   assign cy   = $signed({2'b00, py});

   assign hit = (cx >= x_lo) && (cx < x_hi) && (cy >= y_lo) && (cy < y_hi);

   for (genvar c = 0; c < 3; c++) begin : g_key
      assign ch_in[c] = (pix[8*c +: 8] >= key_lo[8*c +: 8]) &&
                        (pix[8*c +: 8] <= key_hi[8*c +: 8]);
   end

   assign keyed = key_en && (&ch_in);
   assign elig  = en && hit && !keyed;
   assign eff_a = lcomp_pkg::scale_alpha(pix[31:24], galpha);
   assign rgb   = pix[23:0];

endmodule

// File: rtl/lcomp_select.sv
module lcomp_select #(
   parameter int NS  = 9,
   parameter int CAP = 6,
   parameter int KW  = 3
) (
   input  logic [NS-1:0]  elig,
   input  logic [7:0]     a_in   [NS],
   input  logic [23:0]    rgb_in [NS],
   input  logic [KW-1:0]  keep,
   output logic [CAP-1:0] sv,
   output logic [7:0]     sa     [CAP],
   output logic [23:0]    srgb   [CAP]
);
   // slot 0 receives the topmost eligible source
   always_comb begin
      int n;
      n  = 0;
      sv = '0;
      for (int s = 0; s < CAP; s++) begin
         sa[s]   = '0;
         srgb[s] = '0;
      end
      for (int i = NS - 1; i >= 0; i--) begin
         if (elig[i] && (n < int'(keep)) && (n < CAP)) begin
            sv[n]   = 1'b1;
            sa[n]   = a_in[i];
            srgb[n] = rgb_in[i];
            n       = n + 1;
         end
      end
   end

endmodule

// File: rtl/lcomp_blend.sv
module lcomp_blend #(
   parameter int CAP = 6
) (
   input  logic [CAP-1:0] sv,
   input  logic [7:0]     sa   [CAP],
   input  logic [23:0]    srgb [CAP],
   input  logic [23:0]    bg,
   output logic [23:0]    rgb
);
   // walk from the deepest filled slot upward; first one found is opaque
   always_comb begin
      logic have;
      have = 1'b0;
      rgb  = bg;
      for (int s = CAP - 1; s >= 0; s--) begin
         if (sv[s]) begin
            if (!have) rgb = srgb[s];
            else       rgb = lcomp_pkg::mix_rgb(sa[s], srgb[s], rgb);
            have = 1'b1;
         end
      end
   end

endmodule

// File: rtl/layer_compositor.sv
module layer_compositor #(
   parameter int NUM_LAYERS = 8,
   parameter int COORD_W    = 12,
   parameter int BLEND_CAP  = 6,
   parameter int EXTRA_W    = 3,
   localparam int NS        = NUM_LAYERS + 1,
   localparam int SEL_W     = $clog2(NS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [SEL_W-1:0]     cfg_sel,
   input  logic                 cfg_en,
   input  logic [COORD_W:0]     cfg_x,
   input  logic [COORD_W:0]     cfg_y,
   input  logic [COORD_W-1:0]   cfg_w,
   input  logic [COORD_W-1:0]   cfg_h,
   input  logic [7:0]           cfg_galpha,
   input  logic                 cfg_key_en,
   input  logic [23:0]          cfg_key_lo,
   input  logic [23:0]          cfg_key_hi,
   input  logic                 glb_we,
   input  logic [EXTRA_W-1:0]   glb_extra,
   input  logic [23:0]          glb_bg,
   input  logic                 frame_start,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [COORD_W-1:0]   in_x,
   input  logic [COORD_W-1:0]   in_y,
   input  logic [32*NS-1:0]     in_pix,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [23:0]          out_rgb
);
   localparam int KW = $clog2(BLEND_CAP + 1);

   // elaboration-time parameter checks
   if (BLEND_CAP < 2 || BLEND_CAP > 6) begin : g_bad_cap
      initial $error("BLEND_CAP must lie in 2..6");
   end
   if (NUM_LAYERS < 1 || COORD_W < 2 || EXTRA_W < 1) begin : g_bad_dims
      initial $error("NUM_LAYERS, COORD_W and EXTRA_W out of range");
   end

   // shadow and working descriptor sets
   logic               sh_en  [NS], act_en  [NS];
   logic [COORD_W:0]   sh_x   [NS], act_x   [NS];
   logic [COORD_W:0]   sh_y   [NS], act_y   [NS];
   logic [COORD_W-1:0] sh_w   [NS], act_w   [NS];
   logic [COORD_W-1:0] sh_h   [NS], act_h   [NS];
   logic [7:0]         sh_ga  [NS], act_ga  [NS];
   logic               sh_ke  [NS], act_ke  [NS];
   logic [23:0]        sh_klo [NS], act_klo [NS];
   logic [23:0]        sh_khi [NS], act_khi [NS];
   logic [EXTRA_W-1:0] sh_extra, act_extra;
   logic [23:0]        sh_bg, act_bg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) begin
            sh_en[i]  <= 1'b0; act_en[i]  <= 1'b0;
            sh_x[i]   <= '0;   act_x[i]   <= '0;
            sh_y[i]   <= '0;   act_y[i]   <= '0;
            sh_w[i]   <= '0;   act_w[i]   <= '0;
            sh_h[i]   <= '0;   act_h[i]   <= '0;
            sh_ga[i]  <= '0;   act_ga[i]  <= '0;
            sh_ke[i]  <= 1'b0; act_ke[i]  <= 1'b0;
            sh_klo[i] <= '0;   act_klo[i] <= '0;
            sh_khi[i] <= '0;   act_khi[i] <= '0;
         end
         sh_extra  <= '0;
         act_extra <= '0;
         sh_bg     <= '0;
         act_bg    <= '0;
      end else begin
         if (cfg_we && (int'(cfg_sel) < NS)) begin
            sh_en[cfg_sel]  <= cfg_en;
            sh_x[cfg_sel]   <= cfg_x;
            sh_y[cfg_sel]   <= cfg_y;
            sh_w[cfg_sel]   <= cfg_w;
            sh_h[cfg_sel]   <= cfg_h;
            sh_ga[cfg_sel]  <= cfg_galpha;
            sh_ke[cfg_sel]  <= cfg_key_en;
            sh_klo[cfg_sel] <= cfg_key_lo;
            sh_khi[cfg_sel] <= cfg_key_hi;
         end
         if (glb_we) begin
            sh_extra <= glb_extra;
            sh_bg    <= glb_bg;
         end
         if (frame_start) begin
            act_en  <= sh_en;
            act_x   <= sh_x;
            act_y   <= sh_y;
            act_w   <= sh_w;
            act_h   <= sh_h;
            act_ga  <= sh_ga;
            act_ke  <= sh_ke;
            act_klo <= sh_klo;
            act_khi <= sh_khi;
            act_extra <= sh_extra;
            act_bg    <= sh_bg;
         end
      end
   end

   // blend depth from the extra-slot setting, clamped to the cap
   logic [KW-1:0] keep_now;
   always_comb begin
      if (int'(act_extra) > BLEND_CAP - 2) keep_now = KW'(BLEND_CAP);
      else                                 keep_now = KW'(int'(act_extra) + 2);
   end

   // stage 0 (combinational): per-source coverage, key and alpha
   logic [NS-1:0] elig_w;
   logic [7:0]    a_w   [NS];
   logic [23:0]   rgb_w [NS];

   for (genvar i = 0; i < NS; i++) begin : g_probe
      lcomp_probe #(.COORD_W(COORD_W)) u_probe (
         .en     (act_en[i]),
         .pos_x  (act_x[i]),
         .pos_y  (act_y[i]),
         .size_w (act_w[i]),
         .size_h (act_h[i]),
         .galpha (act_ga[i]),
         .key_en (act_ke[i]),
         .key_lo (act_klo[i]),
         .key_hi (act_khi[i]),
         .px     (in_x),
         .py     (in_y),
         .pix    (in_pix[32*i +: 32]),
         .elig   (elig_w[i]),
         .eff_a  (a_w[i]),
         .rgb    (rgb_w[i])
      );
   end

   // pipeline registers
   logic          adv;
   logic          s1_v, s2_v, o_v;
   logic [NS-1:0] s1_elig;
   logic [7:0]    s1_a   [NS];
   logic [23:0]   s1_rgb [NS];
   logic [KW-1:0] s1_keep;
   logic [23:0]   s1_bg, s2_bg, o_rgb;
   logic [BLEND_CAP-1:0] sel_v, s2_sv;
   logic [7:0]    sel_a    [BLEND_CAP], s2_sa   [BLEND_CAP];
   logic [23:0]   sel_rgb  [BLEND_CAP], s2_srgb [BLEND_CAP];
   logic [23:0]   blend_w;

   assign adv      = !o_v || out_ready;
   assign in_ready = adv;

   lcomp_select #(.NS(NS), .CAP(BLEND_CAP), .KW(KW)) u_select (
      .elig   (s1_elig),
      .a_in   (s1_a),
      .rgb_in (s1_rgb),
      .keep   (s1_keep),
      .sv     (sel_v),
      .sa     (sel_a),
      .srgb   (sel_rgb)
   );

   lcomp_blend #(.CAP(BLEND_CAP)) u_blend (
      .sv   (s2_sv),
      .sa   (s2_sa),
      .srgb (s2_srgb),
      .bg   (s2_bg),
      .rgb  (blend_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s2_v    <= 1'b0;
         o_v     <= 1'b0;
         s1_elig <= '0;
         s1_keep <= '0;
         s1_bg   <= '0;
         s2_bg   <= '0;
         s2_sv   <= '0;
         o_rgb   <= '0;
         for (int i = 0; i < NS; i++) begin
            s1_a[i]   <= '0;
            s1_rgb[i] <= '0;
         end
         for (int s = 0; s < BLEND_CAP; s++) begin
            s2_sa[s]   <= '0;
            s2_srgb[s] <= '0;
         end
      end else if (adv) begin
         s1_v    <= in_valid;
         s1_elig <= elig_w;
         s1_a    <= a_w;
         s1_rgb  <= rgb_w;
         s1_keep <= keep_now;
         s1_bg   <= act_bg;
         s2_v    <= s1_v;
         s2_sv   <= sel_v;
         s2_sa   <= sel_a;
         s2_srgb <= sel_rgb;
         s2_bg   <= s1_bg;
         o_v     <= s2_v;
         o_rgb   <= blend_w;
      end
   end

   assign out_valid = o_v;
   assign out_rgb   = o_rgb;

endmodule

// File: rtl/layer_compositor_chk.sv
module layer_compositor_chk #(
   parameter int EXTRA_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_ready,
   input logic               out_valid,
   input logic               out_ready,
   input logic [23:0]        out_rgb,
   input logic               frame_start,
   input logic [23:0]        act_bg,
   input logic [EXTRA_W-1:0] act_extra
);
   logic [2:0] occ;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= '0;
      else occ <= occ + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
   end

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_rgb));

   // R10
   refuse_only_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> out_valid && !out_ready);

   // R10
   inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= 3'd3);

   // R10
   no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> occ != 3'd0);

   // R9
   commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(act_bg) && $stable(act_extra));

endmodule

bind layer_compositor layer_compositor_chk #(.EXTRA_W(EXTRA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_rgb     (out_rgb),
   .frame_start (frame_start),
   .act_bg      (act_bg),
   .act_extra   (act_extra)
);

// File: tb/layer_compositor_tb.sv
module layer_compositor_tb;
   localparam int NL = 8;
   localparam int NS = NL + 1;
   localparam int CW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          cfg_we = 0;
   logic [3:0]    cfg_sel = 0;
   logic          cfg_en = 0;
   logic [CW:0]   cfg_x = 0, cfg_y = 0;
   logic [CW-1:0] cfg_w = 0, cfg_h = 0;
   logic [7:0]    cfg_galpha = 0;
   logic          cfg_key_en = 0;
   logic [23:0]   cfg_key_lo = 0, cfg_key_hi = 0;
   logic          glb_we = 0;
   logic [2:0]    glb_extra = 0;
   logic [23:0]   glb_bg = 0;
   logic          frame_start = 0;
   logic          in_valid = 0, in_ready;
   logic [CW-1:0] in_x = 0, in_y = 0;
   logic [32*NS-1:0] in_pix;
   logic          out_valid, out_ready = 1;
   logic [23:0]   out_rgb;
   logic [31:0]   pix [NS];

   always_comb for (int i = 0; i < NS; i++) in_pix[32*i +: 32] = pix[i];

   layer_compositor u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
      .cfg_x(cfg_x), .cfg_y(cfg_y), .cfg_w(cfg_w), .cfg_h(cfg_h),
      .cfg_galpha(cfg_galpha), .cfg_key_en(cfg_key_en), .cfg_key_lo(cfg_key_lo),
      .cfg_key_hi(cfg_key_hi), .glb_we(glb_we), .glb_extra(glb_extra), .glb_bg(glb_bg),
      .frame_start(frame_start), .in_valid(in_valid), .in_ready(in_ready),
      .in_x(in_x), .in_y(in_y), .in_pix(in_pix), .out_valid(out_valid),
      .out_ready(out_ready), .out_rgb(out_rgb)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
      end
   endtask

   task automatic cfg_layer(input int idx, input bit en, input int x, input int y,
                            input int w, input int h, input int ga, input bit ken,
                            input logic [23:0] lo, input logic [23:0] hi);
      @(negedge clk);
      cfg_we = 1; cfg_sel = 4'(idx); cfg_en = en;
      cfg_x = 13'(x); cfg_y = 13'(y); cfg_w = 12'(w); cfg_h = 12'(h);
      cfg_galpha = 8'(ga); cfg_key_en = ken; cfg_key_lo = lo; cfg_key_hi = hi;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic cfg_glb(input int extra, input logic [23:0] bg);
      @(negedge clk);
      glb_we = 1; glb_extra = 3'(extra); glb_bg = bg;
      @(negedge clk);
      glb_we = 0;
   endtask

   task automatic commit();
      @(negedge clk);
      frame_start = 1;
      @(negedge clk);
      frame_start = 0;
   endtask

   task automatic run_pix(input int x, input int y, output logic [23:0] res);
      @(negedge clk);
      in_x = 12'(x); in_y = 12'(y); in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      for (int k = 0; k < 20 && !out_valid; k++) @(negedge clk);
      res = out_valid ? out_rgb : 24'hxxxxxx;
   endtask

   // x, y, expected RGB under the main configuration
   localparam logic [55:0] VEC [16] = '{
      {16'd0,   16'd0,   24'h880808},   // R1 R6 two layers blended
      {16'd19,  16'd19,  24'h880808},   // R1 last covered column/row of negative origin
      {16'd20,  16'd20,  24'h101010},   // R1 right edge excluded
      {16'd19,  16'd20,  24'h101010},   // R1 bottom edge excluded
      {16'd99,  16'd99,  24'h101010},   // R1
      {16'd100, 16'd50,  24'h123456},   // R7 R8 only disabled layers
      {16'd55,  16'd55,  24'h101010},   // R5 keyed layer transparent
      {16'd200, 16'd0,   24'h202020},   // R2 higher layer hides lower
      {16'd204, 16'd4,   24'h202020},   // R2
      {16'd205, 16'd4,   24'h0000FF},   // R1 R2
      {16'd209, 16'd9,   24'h0000FF},   // R1
      {16'd210, 16'd9,   24'h123456},   // R7
      {16'd300, 16'd300, 24'hABCDEF},   // R2 cursor
      {16'd301, 16'd301, 24'hABCDEF},   // R2
      {16'd302, 16'd301, 24'h123456},   // R7
      {16'd500, 16'd500, 24'h123456}    // R7 R8
   };

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_err++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      logic [23:0] r;
      for (int i = 0; i < NS; i++) pix[i] = 32'h0;

      // R11 reset state
      repeat (3) @(negedge clk);
      check("R11 out_valid in reset", {23'd0, out_valid}, 24'd0);
      rst_n = 1;
      @(negedge clk);
      check("R11 in_ready after reset", {23'd0, in_ready}, 24'd1);
      run_pix(0, 0, r);
      check("R11 unconfigured output", r, 24'h000000);

      // main configuration
      pix[0] = 32'hFF101010; pix[1] = 32'h80FF0000; pix[2] = 32'hFF00FF00;
      pix[3] = 32'hFF0000FF; pix[4] = 32'hFF202020; pix[5] = 32'hFFEEEEEE;
      pix[6] = 32'hFFEEEEEE; pix[7] = 32'hFFEEEEEE; pix[8] = 32'hFFABCDEF;
      cfg_layer(0, 1, 0, 0, 100, 100, 255, 0, 0, 0);
      cfg_layer(1, 1, -10, -10, 30, 30, 255, 0, 0, 0);
      cfg_layer(2, 1, 50, 50, 20, 20, 255, 1, 24'h00F000, 24'h10FF10);
      cfg_layer(3, 1, 200, 0, 10, 10, 255, 0, 0, 0);
      cfg_layer(4, 1, 200, 0, 5, 5, 255, 0, 0, 0);
      for (int i = 5; i < 8; i++) cfg_layer(i, 0, 0, 0, 4095, 4095, 255, 0, 0, 0);
      cfg_layer(8, 1, 300, 300, 2, 2, 255, 0, 0, 0);
      cfg_glb(0, 24'h123456);
      commit();

      for (int v = 0; v < 16; v++) begin
         run_pix(int'(VEC[v][55:40]), int'(VEC[v][39:24]), r);
         check($sformatf("R1/R2/R5/R7 vector %0d", v), r, VEC[v][23:0]);
      end

      // R5 key limits are inclusive
      pix[2] = 32'hFF10FF10;
      run_pix(55, 55, r);
      check("R5 pixel on upper key limit", r, 24'h101010);
      pix[2] = 32'hFF11FF10;
      run_pix(55, 55, r);
      check("R5 pixel just outside key", r, 24'h11FF10);
      pix[2] = 32'hFF00FF00;

      // R9 shadow write invisible until frame start
      cfg_glb(0, 24'h654321);
      run_pix(500, 500, r);
      check("R9 before commit", r, 24'h123456);
      commit();
      run_pix(500, 500, r);
      check("R9 after commit", r, 24'h654321);

      // R10 back-pressure and ordering
      @(negedge clk);
      out_ready = 0; in_valid = 1; in_x = 0; in_y = 0;
      @(negedge clk);
      in_x = 20; in_y = 20;
      @(negedge clk);
      in_x = 300; in_y = 300;
      @(negedge clk);
      in_x = 500; in_y = 500;
      check("R10 first result under stall", out_rgb, 24'h880808);
      check("R10 in_ready low when full", {23'd0, in_ready}, 24'd0);
      @(negedge clk);
      check("R10 output held", out_rgb, 24'h880808);
      @(negedge clk);
      check("R10 output still held", {out_valid, out_rgb}, {1'b1, 24'h880808});
      out_ready = 1;
      @(negedge clk);
      in_valid = 0;
      check("R10 second in order", out_rgb, 24'h101010);
      @(negedge clk);
      check("R10 third in order", out_rgb, 24'hABCDEF);
      @(negedge clk);
      check("R10 refused pixel kept", {out_valid, out_rgb}, {1'b1, 24'h654321});

      // R10 latency of three edges
      @(negedge clk);
      in_valid = 1; in_x = 0; in_y = 0;
      @(negedge clk);
      in_valid = 0;
      check("R10 not valid after one edge", {23'd0, out_valid}, 24'd0);
      @(negedge clk);
      check("R10 not valid after two edges", {23'd0, out_valid}, 24'd0);
      @(negedge clk);
      check("R10 valid after three edges", {out_valid, out_rgb}, {1'b1, 24'h880808});

      // R3 R4 depth cap; R5 keyed layer takes no slot
      pix[0] = 32'hFF0000FF; pix[1] = 32'h80FF0000; pix[3] = 32'h8000FF00;
      pix[4] = 32'hFF777777;
      cfg_layer(0, 1, 0, 0, 10, 10, 255, 0, 0, 0);
      cfg_layer(1, 1, 0, 0, 10, 10, 255, 0, 0, 0);
      cfg_layer(2, 0, 0, 0, 10, 10, 255, 0, 0, 0);
      cfg_layer(3, 1, 0, 0, 10, 10, 255, 0, 0, 0);
      cfg_layer(4, 1, 0, 0, 10, 10, 255, 1, 24'h777777, 24'h777777);
      cfg_layer(8, 1, 900, 900, 2, 2, 255, 0, 0, 0);
      cfg_glb(0, 24'h123456);
      commit();
      run_pix(0, 0, r);
      check("R3 R4 two slots, bottom opaque", r, 24'h7F8000);
      cfg_glb(1, 24'h123456);
      commit();
      run_pix(0, 0, r);
      check("R3 three slots", r, 24'h40803F);
      cfg_glb(7, 24'h123456);
      commit();
      run_pix(0, 0, r);
      check("R3 extra beyond cap clamps", r, 24'h40803F);

      // R6 global alpha scales pixel alpha
      pix[3] = 32'hFF00FF00;
      cfg_layer(3, 1, 0, 0, 10, 10, 128, 0, 0, 0);
      cfg_glb(0, 24'h123456);
      commit();
      run_pix(0, 0, r);
      check("R6 global alpha", r, 24'h7F8000);

      // R8 enabling a covering layer makes it visible
      cfg_layer(5, 1, 0, 0, 4095, 4095, 255, 0, 0, 0);
      commit();
      run_pix(0, 0, r);
      check("R8 enabled layer on top", r, 24'hEEEEEE);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule